// File: doc/BRIEF.md
# ChaCha Double-Round Permutation Core

The core takes a sixteen-word state of 32-bit words and applies the ChaCha permutation to it, which is ten double rounds (twenty rounds) of quarter-rounds. It is meant for HChaCha20 subkey derivation. For that reason the permuted state is returned exactly as it leaves the last round, and the input state is not added back at the end.

The core has one shared quarter-round datapath (adders, XORs and fixed rotates) and applies it once per clock. A seven-bit schedule counter steps through 80 quarter-rounds:

- Its low three bits choose one of eight word tuples. Values 0 to 3 are the four column tuples and values 4 to 7 are the four diagonal tuples.
- Its upper bits count the double rounds.

A host presents the state on `state_in` and pulses `start`. After the run, `done` pulses for one cycle and the result appears on `state_out`. The result stays there until the next accepted start.

Top module: `chacha_perm`

## Requirements
- R1: Word i of the state is carried on bits [32*i+31:32*i] of both `state_in` and `state_out`. After a run, `state_out` equals the 20-round ChaCha permutation of the loaded state. The input state is not added to the result.
- R2: Each quarter-round on words (a,b,c,d) performs, in this order: a=a+b, d=rotl(d^a,16); c=c+d, b=rotl(b^c,12); a=a+b, d=rotl(d^a,8); c=c+d, b=rotl(b^c,7). All additions are modulo 2^32.
- R3: Each double round first applies the column tuples (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15). It then applies the diagonal tuples (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). Both groups run in the order listed, and the double round repeats ten times.
- R4: A start is accepted on a rising edge where `start` is 1 and `busy` is 0. `done` then becomes 1 after the 80th following rising edge, and it stays 1 for exactly one cycle.
- R5: `busy` is 1 from the edge that accepts a start until the edge that raises `done`. `busy` and `done` are never both 1.
- R6: `start` is ignored while `busy` is 1. The state and input presented at that time do not alter the result of the run in progress.
- R7: While `busy` is 0 and no start is accepted, `state_out` does not change, whatever `state_in` does.
- R8: Synchronous active-high `rst` clears `busy` and `done`. A run cut short by reset produces no `done` pulse.
- R9: An all-zero state permutes to an all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load `state_in` and begin a run |
| state_in | input | 512 | Input state, word i at bits 32i upward |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: result valid |
| state_out | output | 512 | Permuted state, held until the next start |

## Verification
The assertions check the handshake on every cycle:

- `done` lasts a single cycle.
- `busy` and `done` never overlap.
- `done` arrives exactly 80 busy cycles after the accepted start.
- The output holds steady while the core is idle.
- Reset leaves the core idle.

The correctness of the permuted words, covering the step order, the rotate amounts and the column-then-diagonal tuple order, can only be shown by the bench. It compares each result with an independent model. It also checks the ignored mid-run start, the zero-state case and the aborted run.

// File: rtl/chacha_perm.sv
module chacha_perm #(
  parameter int DROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [511:0] state_in,
  output logic         busy,
  output logic         done,
  output logic [511:0] state_out
);
  localparam int QRS = 8 * DROUNDS;
  localparam int CW  = $clog2(QRS);

  logic [CW-1:0] idx;
  logic [31:0]   st [16];

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  wire [1:0] k    = idx[1:0];
  wire       diag = idx[2];
  wire [3:0] ia = {2'b00, k};
  wire [3:0] ib = {2'b01, k + {1'b0, diag}};
  wire [3:0] ic = {2'b10, k + {diag, 1'b0}};
  wire [3:0] id = {2'b11, k + {diag, diag}};

  wire [31:0] a0 = st[ia];
  wire [31:0] b0 = st[ib];
  wire [31:0] c0 = st[ic];
  wire [31:0] d0 = st[id];

  wire [31:0] a1 = a0 + b0;
  wire [31:0] d1 = rotl(d0 ^ a1, 16);
  wire [31:0] c1 = c0 + d1;
  wire [31:0] b1 = rotl(b0 ^ c1, 12);
  wire [31:0] a2 = a1 + b1;
  wire [31:0] d2 = rotl(d1 ^ a2, 8);
  wire [31:0] c2 = c1 + d2;
  wire [31:0] b2 = rotl(b1 ^ c2, 7);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        for (int i = 0; i < 16; i++) st[i] <= state_in[32*i +: 32];
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        for (int i = 0; i < 16; i++) begin
          if (4'(i) == ia)      st[i] <= a2;
          else if (4'(i) == ib) st[i] <= b2;
          else if (4'(i) == ic) st[i] <= c2;
          else if (4'(i) == id) st[i] <= d2;
        end
        if (idx == CW'(QRS - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < 16; g++) begin : g_out
    assign state_out[32*g +: 32] = st[g];
  end
endmodule

module chacha_perm_chk #(
  parameter int DROUNDS = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [511:0] state_out
);
  localparam int QRS = 8 * DROUNDS;
  int unsigned cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= 0;
    else if (!busy && start) cnt <= 0;
    else if (busy)           cnt <= cnt + 1;
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> cnt == QRS);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(state_out));
  // R8
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !done));
endmodule

bind chacha_perm chacha_perm_chk #(.DROUNDS(DROUNDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .state_out(state_out)
);

// File: tb/chacha_perm_bench.sv
module chacha_perm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [511:0] state_in = '0;
  logic busy, done;
  logic [511:0] state_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  chacha_perm u_chacha_perm (
    .clk(clk), .rst(rst), .start(start), .state_in(state_in),
    .busy(busy), .done(done), .state_out(state_out)
  );

  localparam logic [31:0] SEEDS [5] = '{32'h61707865, 32'h00000001, 32'hFFFFFFFF,
                                        32'h3320646E, 32'hDEADBEEF};

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [511:0] model(input logic [511:0] s);
    logic [31:0] w [16];
    int t [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                     '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    logic [511:0] r;
    for (int i = 0; i < 16; i++) w[i] = s[32*i +: 32];
    for (int n = 0; n < 10; n++)
      for (int q = 0; q < 8; q++) begin
        w[t[q][0]] = w[t[q][0]] + w[t[q][1]]; w[t[q][3]] = rl(w[t[q][3]] ^ w[t[q][0]], 16);
        w[t[q][2]] = w[t[q][2]] + w[t[q][3]]; w[t[q][1]] = rl(w[t[q][1]] ^ w[t[q][2]], 12);
        w[t[q][0]] = w[t[q][0]] + w[t[q][1]]; w[t[q][3]] = rl(w[t[q][3]] ^ w[t[q][0]], 8);
        w[t[q][2]] = w[t[q][2]] + w[t[q][3]]; w[t[q][1]] = rl(w[t[q][1]] ^ w[t[q][2]], 7);
      end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = w[i];
    return r;
  endfunction

  function automatic logic [511:0] expand(input logic [31:0] seed);
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[32*i +: 32] = (seed + 32'(i) * 32'h9E3779B9) ^ (seed >> i);
    return r;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start a run, then count edges until done; returns edge number of done (0 if none in limit)
  task automatic run(input logic [511:0] s, input int stray_at, input logic [511:0] stray,
                     output int done_edge, output int busy_bad);
    done_edge = 0; busy_bad = 0;
    @(negedge clk); state_in = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; state_in = ~s;
    for (int e = 1; e <= 90; e++) begin
      if (e == stray_at) begin start = 1'b1; state_in = stray; end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done && done_edge == 0) done_edge = e;
      if (e < 80 && !busy) busy_bad++;
      if (e >= 80 && busy) busy_bad++;
    end
  endtask

  initial begin
    int de, bb;
    logic [511:0] held;
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int de, bb;
    logic [511:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R8 reset busy", {511'b0, busy}, '0);
    check("R8 reset done", {511'b0, done}, '0);

    for (int v = 0; v < 5; v++) begin
      run(expand(SEEDS[v]), 0, '0, de, bb);
      check("R4 done edge", 512'(de), 512'd80);
      check("R5 busy window", 512'(bb), '0);
      check("R1 R2 R3 result", state_out, model(expand(SEEDS[v])));
    end

    run('0, 0, '0, de, bb);
    check("R9 zero state", state_out, '0);

    run(expand(32'h12345678), 20, expand(32'h0BADF00D), de, bb);
    check("R6 stray start ignored", state_out, model(expand(32'h12345678)));
    check("R6 done edge", 512'(de), 512'd80);

    held = state_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); state_in = expand(32'(i));
    end
    check("R7 output held", state_out, held);

    @(negedge clk); state_in = expand(32'hCAFE0001); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R8 abort busy", {511'b0, busy}, '0);
    de = 0;
    for (int e = 0; e < 90; e++) begin
      @(posedge clk); @(negedge clk);
      if (done) de++;
    end
    check("R8 no done after abort", 512'(de), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule